// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block brings up one serial link port after a start request. It first presents fixed PHY and port settings with training held off. It then switches on port power and releases PHY power-down. The core clock comes on one cycle later, then the reference clock. After that it drives a timed active-low reset pulse to the endpoint and finally enables link training. While it waits for the link, it counts polling attempts against a bound.

The link-status input is asynchronous and passes through a two-flop synchroniser before the block samples it. The block checks it once per polling cycle. A diagnostic strobe marks every wrap of the poll period and the final attempt, so that surrounding logic can capture debug words at those points. When the link is seen, the block holds a settle period of two equal phases and then reports link-up. When the attempt budget runs out, it reports link-down. A new start is accepted only when idle or after a result, and it repeats the whole sequence from the top. Every duration is a parameter counted in clock cycles.

Top module: `link_bringup_seq`

## Requirements
- R1: Out of reset and while idle, phy_pd_o=1 and perst_n_o=1, and every other control and status output is 0.
- R2: The constant outputs always hold port type 4 (root port), loss-of-signal level 9, de-emphasis values 21, 21 and 32, and swing values 115 and 115. train_en_o is 0 from the start pulse until the reset pulse has ended.
- R3: On the cycle after an accepted start pulse, the block spends one configuration cycle. Then pwr_en_o rises and phy_pd_o falls together, and clk_en_o rises exactly one cycle later. refclk_en_o rises PWR_CYC cycles after pwr_en_o.
- R4: perst_n_o falls exactly REFCLK_CYC cycles after refclk_en_o rises.
- R5: perst_n_o stays low for exactly PERST_CYC cycles. train_en_o rises in the same cycle that perst_n_o returns high, and is never 1 while perst_n_o is 0.
- R6: A start pulse during the sequence (any phase other than idle, link-up or link-down) has no effect, and the phase timing continues unchanged.
- R7: Poll attempt j is the (j+1)-th cycle after the training cycle. A change of link_stat_i becomes visible to polling two clock edges after it is applied. When the link is seen on an attempt j ≤ POLL_MAX-1, link_up_o rises 2*SETTLE_CYC+1 cycles after that attempt.
- R8: If no link is seen on attempts 0 to POLL_MAX-1, link_down_o rises on the cycle after the last attempt.
- R9: diag_strobe_o pulses for one cycle on each attempt j with (j+1) mod DIAG_PERIOD = 0, and on attempt POLL_MAX-1, provided the link is not seen on that attempt. It pulses at no other time.
- R10: A start pulse in link-up or link-down repeats the full sequence from the configuration cycle. Changes of link_stat_i while in link-up or link-down have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| link_stat_i | input | 1 | Asynchronous link-up status bit |
| phy_pd_o | output | 1 | PHY power-down, active high |
| pwr_en_o | output | 1 | Port power enable |
| clk_en_o | output | 1 | Core clock enable |
| refclk_en_o | output | 1 | Reference clock enable |
| perst_n_o | output | 1 | Endpoint reset, active low |
| train_en_o | output | 1 | Link training enable |
| link_up_o | output | 1 | Link came up, held until next start |
| link_down_o | output | 1 | Poll budget ran out, held until next start |
| diag_strobe_o | output | 1 | Diagnostic capture strobe |
| port_type_o | output | 4 | Constant port type |
| los_level_o | output | 5 | Constant loss-of-signal level |
| deemph_a_o | output | 6 | Constant de-emphasis, low rate |
| deemph_b_o | output | 6 | Constant de-emphasis, high rate mild |
| deemph_c_o | output | 6 | Constant de-emphasis, high rate strong |
| swing_full_o | output | 7 | Constant full swing |
| swing_low_o | output | 7 | Constant low swing |

## Verification
A wrong phase state or a miscounted phase timer shows up right away as an enable edge that comes one or more cycles off the expected spacing. It can also show up as training enabled while the endpoint is still in reset. A fault in the poll counter or the synchroniser shows up later, at the end of polling. In that case link_up_o or link_down_o arrives in the wrong cycle or with the wrong outcome at the boundary attempts, or the number of diagnostic strobes seen during the poll does not match the count worked out from POLL_MAX and DIAG_PERIOD.

// File: rtl/lbs_pkg.sv
// Shared types and constant settings for the link bring-up sequencer.
// Assumes the state encoding is ordered so that "at or past phase X"
// can be decoded with a magnitude compare.
package lbs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CFG    = 4'd1,
        ST_PWR    = 4'd2,
        ST_REFCLK = 4'd3,
        ST_PERST  = 4'd4,
        ST_TRAIN  = 4'd5,
        ST_POLL   = 4'd6,
        ST_SETTLE = 4'd7,
        ST_UP     = 4'd8,
        ST_DOWN   = 4'd9
    } lbs_state_e;

    localparam logic [3:0] PORT_TYPE_ROOT = 4'd4;
    localparam logic [4:0] LOS_LEVEL      = 5'd9;
    localparam logic [5:0] DEEMPH_A       = 6'd21;
    localparam logic [5:0] DEEMPH_B       = 6'd21;
    localparam logic [5:0] DEEMPH_C       = 6'd32;
    localparam logic [6:0] SWING_FULL     = 7'd115;
    localparam logic [6:0] SWING_LOW      = 7'd115;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/lbs_sync.sv
// Multi-flop synchroniser for one asynchronous level input.
// Assumes the input is a slow level, so no pulse stretching is needed.
module lbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lbs_timer.sv
// Loadable down-counter used to time each sequencer phase.
// A phase loaded with N-1 on entry lasts exactly N cycles; zero_o is
// high in the last cycle. Assumes load_val fits in W bits.
module lbs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    // reload on phase entry, otherwise count down and stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load_i)       cnt <= load_val_i;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/lbs_poll.sv
// Poll attempt counter with periodic diagnostic strobe.
// One attempt per active cycle; last_o flags the final allowed attempt.
// The strobe fires on each period wrap and on the final attempt unless
// the link is seen in that same cycle. Assumes clr_i precedes polling.
module lbs_poll #(
    parameter int POLL_MAX    = 1024,
    parameter int DIAG_PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic active_i,
    input  logic link_i,
    output logic last_o,
    output logic diag_o
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam int DW = $clog2(DIAG_PERIOD + 1);

    logic [PW-1:0] pcnt;
    logic [DW-1:0] dcnt;
    logic          wrap;

    assign wrap = (dcnt == DW'(DIAG_PERIOD - 1));

    // count attempts and the position inside the diagnostic period
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (active_i) begin
            pcnt <= pcnt + 1'b1;
            dcnt <= wrap ? '0 : dcnt + 1'b1;
        end
    end

    assign last_o = (pcnt == PW'(POLL_MAX - 1));
    assign diag_o = active_i && !link_i && (wrap || last_o);
endmodule

// File: rtl/link_bringup_seq.sv
// Link bring-up and reset sequencer, top level.
// Walks config -> power -> clocks -> endpoint reset -> training -> poll ->
// settle, then reports link up or down. Start is honoured only when idle
// or after a result. Assumes PWR_CYC >= 2 so the core clock is on before
// the reference clock, and all durations >= 1.
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int PWR_CYC     = 2500,
    parameter int REFCLK_CYC  = 2500,
    parameter int PERST_CYC   = 25000000,
    parameter int SETTLE_CYC  = 875000,
    parameter int POLL_MAX    = 1048576,
    parameter int DIAG_PERIOD = 262144
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       link_stat_i,
    output logic       phy_pd_o,
    output logic       pwr_en_o,
    output logic       clk_en_o,
    output logic       refclk_en_o,
    output logic       perst_n_o,
    output logic       train_en_o,
    output logic       link_up_o,
    output logic       link_down_o,
    output logic       diag_strobe_o,
    output logic [3:0] port_type_o,
    output logic [4:0] los_level_o,
    output logic [5:0] deemph_a_o,
    output logic [5:0] deemph_b_o,
    output logic [5:0] deemph_c_o,
    output logic [6:0] swing_full_o,
    output logic [6:0] swing_low_o
);
    localparam int SETTLE_TOT = 2 * SETTLE_CYC;
    localparam int MAX_DUR    = max_of(max_of(PWR_CYC, REFCLK_CYC),
                                       max_of(PERST_CYC, SETTLE_TOT));
    localparam int TW         = $clog2(MAX_DUR + 1);

    lbs_state_e    st, st_n;
    logic          link_s;
    logic          tmr_zero;
    logic          poll_last;
    logic [TW-1:0] tmr_val;
    logic          clk_en_q;
    logic          pwr_on;

    lbs_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (link_stat_i),
        .q_o   (link_s)
    );

    // duration to load on entry to the next phase
    always_comb begin
        case (st_n)
            ST_PWR:    tmr_val = TW'(PWR_CYC - 1);
            ST_REFCLK: tmr_val = TW'(REFCLK_CYC - 1);
            ST_PERST:  tmr_val = TW'(PERST_CYC - 1);
            ST_SETTLE: tmr_val = TW'(SETTLE_TOT - 1);
            default:   tmr_val = '0;
        endcase
    end

    lbs_timer #(.W(TW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (st_n != st),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    lbs_poll #(.POLL_MAX(POLL_MAX), .DIAG_PERIOD(DIAG_PERIOD)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (st == ST_TRAIN),
        .active_i (st == ST_POLL),
        .link_i   (link_s),
        .last_o   (poll_last),
        .diag_o   (diag_strobe_o)
    );

    // next-phase selection
    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE, ST_UP, ST_DOWN: if (start_i) st_n = ST_CFG;
            ST_CFG:    st_n = ST_PWR;
            ST_PWR:    if (tmr_zero) st_n = ST_REFCLK;
            ST_REFCLK: if (tmr_zero) st_n = ST_PERST;
            ST_PERST:  if (tmr_zero) st_n = ST_TRAIN;
            ST_TRAIN:  st_n = ST_POLL;
            ST_POLL: begin
                if (link_s)         st_n = ST_SETTLE;
                else if (poll_last) st_n = ST_DOWN;
            end
            ST_SETTLE: if (tmr_zero) st_n = ST_UP;
            default:   st_n = ST_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // core clock follows power by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) clk_en_q <= 1'b0;
        else        clk_en_q <= pwr_on;
    end

    assign pwr_on        = (st >= ST_PWR);
    assign pwr_en_o      = pwr_on;
    assign phy_pd_o      = !pwr_on;
    assign clk_en_o      = clk_en_q && pwr_on;
    assign refclk_en_o   = (st >= ST_REFCLK);
    assign perst_n_o     = (st != ST_PERST);
    assign train_en_o    = (st >= ST_TRAIN);
    assign link_up_o     = (st == ST_UP);
    assign link_down_o   = (st == ST_DOWN);

    assign port_type_o   = PORT_TYPE_ROOT;
    assign los_level_o   = LOS_LEVEL;
    assign deemph_a_o    = DEEMPH_A;
    assign deemph_b_o    = DEEMPH_B;
    assign deemph_c_o    = DEEMPH_C;
    assign swing_full_o  = SWING_FULL;
    assign swing_low_o   = SWING_LOW;
endmodule

// File: rtl/link_bringup_seq_chk.sv
// Port-level property checker for link_bringup_seq, bound to every instance.
module link_bringup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic pwr_en_o,
    input logic clk_en_o,
    input logic refclk_en_o,
    input logic perst_n_o,
    input logic train_en_o,
    input logic link_up_o,
    input logic link_down_o,
    input logic diag_strobe_o
);
    // R5: training never enabled while the endpoint is held in reset
    p_no_train_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !perst_n_o |-> !train_en_o);

    // R5: training starts exactly when the reset pulse ends
    p_train_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> $past(!perst_n_o));

    // R3: clocks only with power, reference clock only after core clock
    p_clock_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o |-> pwr_en_o) and (refclk_en_o |-> clk_en_o));

    // R4: reset pulse only with the reference clock running
    p_reset_needs_refclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !perst_n_o |-> refclk_en_o);

    // R8: results are exclusive and down follows a final diagnostic strobe
    p_down_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_down_o) |-> $past(diag_strobe_o) && !link_up_o);

    // R9: strobe only while training and no result reported
    p_strobe_in_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        diag_strobe_o |-> train_en_o && !link_up_o && !link_down_o);

    // R10: a result holds until a new start
    p_up_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o && !start_i |=> link_up_o);
endmodule

bind link_bringup_seq link_bringup_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .pwr_en_o      (pwr_en_o),
    .clk_en_o      (clk_en_o),
    .refclk_en_o   (refclk_en_o),
    .perst_n_o     (perst_n_o),
    .train_en_o    (train_en_o),
    .link_up_o     (link_up_o),
    .link_down_o   (link_down_o),
    .diag_strobe_o (diag_strobe_o)
);

// File: tb/sim_link_bringup_seq.sv
// Self-checking bench: directed boundary runs plus seeded random link timing.
module sim_link_bringup_seq;
    localparam int PWR_CYC = 4, REFCLK_CYC = 3, PERST_CYC = 20, SETTLE_CYC = 5;
    localparam int POLL_MAX = 40, DIAG_PERIOD = 16;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, link_stat_i = 1'b0;
    logic phy_pd_o, pwr_en_o, clk_en_o, refclk_en_o, perst_n_o, train_en_o;
    logic link_up_o, link_down_o, diag_strobe_o;
    logic [3:0] port_type_o;
    logic [4:0] los_level_o;
    logic [5:0] deemph_a_o, deemph_b_o, deemph_c_o;
    logic [6:0] swing_full_o, swing_low_o;

    int checks = 0, failures = 0, cyc = 0;

    always #2 clk = ~clk;

    link_bringup_seq #(.PWR_CYC(PWR_CYC), .REFCLK_CYC(REFCLK_CYC), .PERST_CYC(PERST_CYC),
        .SETTLE_CYC(SETTLE_CYC), .POLL_MAX(POLL_MAX), .DIAG_PERIOD(DIAG_PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_stat_i(link_stat_i),
        .phy_pd_o(phy_pd_o), .pwr_en_o(pwr_en_o), .clk_en_o(clk_en_o),
        .refclk_en_o(refclk_en_o), .perst_n_o(perst_n_o), .train_en_o(train_en_o),
        .link_up_o(link_up_o), .link_down_o(link_down_o), .diag_strobe_o(diag_strobe_o),
        .port_type_o(port_type_o), .los_level_o(los_level_o), .deemph_a_o(deemph_a_o),
        .deemph_b_o(deemph_b_o), .deemph_c_o(deemph_c_o), .swing_full_o(swing_full_o),
        .swing_low_o(swing_low_o));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected strobes for the first n attempts without the link
    function automatic int exp_diag(input int n);
        int c = 0;
        for (int j = 0; j < n; j++)
            if (((j + 1) % DIAG_PERIOD == 0) || (j == POLL_MAX - 1)) c++;
        return c;
    endfunction

    // one full bring-up; link applied on poll-relative negedge a (a<0: never)
    task automatic run(input int a, input bit poke_start);
        int t_pwr = -1, t_clk = -1, t_ref = -1, t_plo = -1, t_phi = -1;
        int t_up = -1, t_dn = -1, ndiag = 0, bad_train = 0, bad_cfg = 0;
        int exp_t;
        link_stat_i = 1'b0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int n = 0; n < 400; n++) begin
            if (t_pwr < 0 && pwr_en_o && !phy_pd_o) t_pwr = n;
            if (t_clk < 0 && clk_en_o) t_clk = n;
            if (t_ref < 0 && refclk_en_o) t_ref = n;
            if (t_plo < 0 && !perst_n_o) t_plo = n;
            if (t_plo >= 0 && t_phi < 0 && perst_n_o) t_phi = n;
            if (train_en_o && (t_phi < 0 || !perst_n_o)) bad_train++;
            if (t_phi >= 0 && train_en_o && t_phi == n && !train_en_o) bad_train++;
            if (port_type_o != 4 || los_level_o != 9 || deemph_a_o != 21 || deemph_b_o != 21
                || deemph_c_o != 32 || swing_full_o != 115 || swing_low_o != 115) bad_cfg++;
            if (diag_strobe_o) ndiag++;
            if (link_up_o) begin t_up = n; break; end
            if (link_down_o) begin t_dn = n; break; end
            if (poke_start && t_plo >= 0 && n == t_plo + 5) start_i = 1'b1;
            if (poke_start && t_plo >= 0 && n == t_plo + 6) start_i = 1'b0;
            if (t_phi >= 0 && a >= 0 && n == t_phi + a) link_stat_i = 1'b1;
            @(negedge clk);
        end
        check("R2 config constants", bad_cfg, 0);
        check("R3 config cycle then power", t_pwr, 1);
        check("R3 clock one cycle after power", t_clk - t_pwr, 1);
        check("R3 power phase length", t_ref - t_pwr, PWR_CYC);
        check("R4 refclk phase length", t_plo - t_ref, REFCLK_CYC);
        check(poke_start ? "R6 reset width with ignored start" : "R5 reset width",
              t_phi - t_plo, PERST_CYC);
        check("R5 training vs reset", bad_train, 0);
        check("R5 training at reset release", int'(t_phi >= 0), 1);
        if (a >= 0 && a + 1 <= POLL_MAX - 1) begin
            exp_t = t_phi + a + 3 + 2 * SETTLE_CYC;
            check("R7 link-up cycle", t_up, exp_t);
            check("R9 strobe count before link", ndiag, exp_diag(a + 1));
        end else begin
            check("R8 link-down cycle", t_dn, t_phi + 1 + POLL_MAX);
            check("R9 strobe count on timeout", ndiag, exp_diag(POLL_MAX));
        end
    endtask

    // watchdog: a hang is a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R1 reset phy_pd", phy_pd_o, 1);
        check("R1 reset perst_n", perst_n_o, 1);
        check("R1 reset others zero", {pwr_en_o, clk_en_o, refclk_en_o, train_en_o,
              link_up_o, link_down_o, diag_strobe_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle holds", {phy_pd_o, perst_n_o, pwr_en_o, train_en_o, link_up_o}, 5'b11000);
        link_stat_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 link ignored in idle", {link_up_o, train_en_o}, 0);
        run(-1, 1'b0);
        run(0, 1'b0);
        // R10: link change while up has no effect
        link_stat_i = 1'b0;
        repeat (8) @(negedge clk);
        check("R10 up held after link drop", {link_up_o, link_down_o, train_en_o}, 3'b101);
        run(POLL_MAX - 2, 1'b1);
        run(POLL_MAX - 1, 1'b0);
        link_stat_i = 1'b1;
        repeat (8) @(negedge clk);
        check("R10 down held after link rise", {link_up_o, link_down_o}, 2'b01);
        for (int k = 0; k < 6; k++) run(int'($urandom % (POLL_MAX + 6)), 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule